// File: doc/BRIEF.md
# Reduced-Half-Adder Wallace Tree Multiplier

This block multiplies two unsigned N-bit integers and returns the full 2N-bit product. It is purely combinational: the product follows the operands within the same clock period, with no register anywhere on the path. N defaults to 10 and is a parameter. Every stage of the tree, and every column inside a stage, is generated from elaboration-time arithmetic on N.

The work splits into three phases. First, the AND array forms every partial-product bit and packs each weight column down to its lowest slots. The matrix then has an inverted-pyramid outline: column c holds c+1 bits below weight N, and 2N-1-c bits from there up.

Second, the matrix is reduced in stages. In each column the bits are taken three at a time into full adders. A sum stays in its own column and a carry moves one column up. A leftover of one or two bits passes through unchanged. The row bound for each stage follows r_next = 2*floor(r/3) + (r mod 3). Only when a column would exceed that bound are its two leftover bits merged by a half adder. The stages stop at two rows, and a carry-propagate adder then forms the product.

Top module: `wallace_mult`

## Requirements
- R1: For every pair of unsigned operands, prod_o equals a_i multiplied by b_i, taken as a 2N-bit unsigned value.
- R2: When either operand is zero, prod_o is zero.
- R3: When one operand is one, prod_o equals the other operand, zero-extended to 2N bits.
- R4: When both operands are all ones, prod_o equals (2^N-1)^2, which for N=10 is 1046529.
- R5: When b_i is 2^k for k in 0..N-1, prod_o equals a_i shifted left by k bit positions.
- R6: The block has no state. prod_o settles to the product of the current operands within the same clock period as an operand change, without any clock edge.
- R7: Swapping a_i and b_i leaves prod_o unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First unsigned operand (multiplicand) |
| b_i | input | N | Second unsigned operand (multiplier) |
| prod_o | output | 2N | Unsigned product of a_i and b_i |

## Verification
Every result of this block is due in the same clock period as the operand change that causes it, because no register lies between the operands and the product. The bench changes the operands 1 ns after a clock edge and reads the product 2 ns later, always before the next edge. This checks that the product settles without any edge, and keeps every comparison clear of the edges.

// File: rtl/wt_pkg.sv
package wt_pkg;

   // Largest column count the planning arrays can hold (N up to 128).
   localparam int MAX_COLS = 256;

   // Row bound after one reduction stage.
   function automatic int next_rows(int r);
      return 2 * (r / 3) + (r % 3);
   endfunction

   // Number of reduction stages needed to reach two rows.
   function automatic int stage_count(int n);
      int r;
      int k;
      r = n;
      k = 0;
      while (r > 2) begin
         r = next_rows(r);
         k++;
      end
      return k;
   endfunction

   // Elaboration-time plan of the tree.
   // sel 0: height of column c at the input of stage s
   // sel 1: 1 when column c of stage s uses a half adder
   // sel 2: row bound at the input of stage s
   function automatic int plan_q(int n, int s, int c, int sel);
      int h  [MAX_COLS];
      int nh [MAX_COLS];
      int w, r, t, cin_fa, cin_ha, f, l, hh, ha_v;
      w = 2 * n;
      for (int k = 0; k < MAX_COLS; k++) begin
         h[k]  = (k < n) ? k + 1 : ((k < w - 1) ? w - 1 - k : 0);
         nh[k] = 0;
      end
      r = n;
      for (int st = 0; st <= s; st++) begin
         t      = next_rows(r);
         cin_fa = 0;
         cin_ha = 0;
         if (st == s && sel == 2) return r;
         for (int k = 0; k < w; k++) begin
            f    = h[k] / 3;
            l    = h[k] % 3;
            hh   = f + l + cin_fa + cin_ha;
            ha_v = 0;
            if (hh > t && l == 2) begin
               ha_v = 1;
               hh   = hh - 1;
            end
            if (st == s && k == c) begin
               if (sel == 0) return h[k];
               return ha_v;
            end
            nh[k]  = hh;
            cin_fa = f;
            cin_ha = ha_v;
         end
         for (int k = 0; k < w; k++) h[k] = nh[k];
         r = t;
      end
      return 0;
   endfunction

endpackage

// File: rtl/wt_fa.sv
module wt_fa (
   input  logic x_i,
   input  logic y_i,
   input  logic z_i,
   output logic sum_o,
   output logic cy_o
);
   assign sum_o = x_i ^ y_i ^ z_i;
   assign cy_o  = (x_i & y_i) | (x_i & z_i) | (y_i & z_i);
endmodule

// File: rtl/wt_ha.sv
module wt_ha (
   input  logic x_i,
   input  logic y_i,
   output logic sum_o,
   output logic cy_o
);
   assign sum_o = x_i ^ y_i;
   assign cy_o  = x_i & y_i;
endmodule

// File: rtl/wt_ppgen.sv
module wt_ppgen #(
   parameter int N = 10
) (
   input  logic [N-1:0]     a_i,
   input  logic [N-1:0]     b_i,
   output logic [2*N*N-1:0] mat_o
);
   localparam int W = 2 * N;

   // Column c, slot k: the k-th AND term of weight c, packed to the bottom.
   for (genvar c = 0; c < W; c++) begin : g_col
      localparam int H = (c < N) ? c + 1 : ((c < W - 1) ? W - 1 - c : 0);
      localparam int J0 = (c < N) ? 0 : c - N + 1;
      for (genvar k = 0; k < N; k++) begin : g_slot
         if (k < H) begin : g_bit
            assign mat_o[c*N+k] = a_i[J0+k] & b_i[c-J0-k];
         end else begin : g_pad
            assign mat_o[c*N+k] = 1'b0;
         end
      end
   end
endmodule

// File: rtl/wt_cpa.sv
module wt_cpa #(
   parameter int W = 20
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   output logic [W-1:0] sum_o
);
   logic cy;

   always_comb begin
      {cy, sum_o} = {1'b0, x_i} + {1'b0, y_i};
      // R1
      cpa_ovf_chk: assert (cy == 1'b0)
         else $error("final two rows overflow the product width");
   end
endmodule

// File: rtl/wallace_mult.sv
module wallace_mult #(
   parameter int N = 10
) (
   input  logic [N-1:0]   a_i,
   input  logic [N-1:0]   b_i,
   output logic [2*N-1:0] prod_o
);
   import wt_pkg::*;

   localparam int W   = 2 * N;
   localparam int NS  = stage_count(N);
   localparam int NSA = (NS > 0) ? NS : 1;
   localparam int AW  = W + 8;

   if (N < 2 || N > 128) begin : g_bad_n
      $error("wallace_mult: N must lie in 2..128");
   end

   logic [W*N-1:0] stg [0:NS];
   logic [W*N-1:0] fco [0:NSA-1];
   logic [W-1:0]   hco [0:NSA-1];
   logic [W-1:0]   row_x, row_y;

   wt_ppgen #(.N(N)) u_pp (.a_i(a_i), .b_i(b_i), .mat_o(stg[0]));

   for (genvar s = 0; s < NS; s++) begin : g_stage
      for (genvar c = 0; c < W; c++) begin : g_col
         localparam int H  = plan_q(N, s, c, 0);
         localparam int HA = plan_q(N, s, c, 1);
         localparam int F  = H / 3;
         localparam int L  = H % 3;
         localparam int FP = (c > 0) ? plan_q(N, s, c - 1, 0) / 3 : 0;
         localparam int HP = (c > 0) ? plan_q(N, s, c - 1, 1) : 0;
         localparam int NL = F + ((HA != 0) ? 1 : L);
         localparam int NH = plan_q(N, s + 1, c, 0);
         localparam int NR = plan_q(N, s + 1, 0, 2);

         if (NL + FP + HP != NH || NH > NR || NH > N) begin : g_bad_plan
            $error("wallace_mult: column plan does not meet the row bound");
         end

         for (genvar g = 0; g < N; g++) begin : g_fa
            if (g < F) begin : g_use
               wt_fa u_fa (
                  .x_i  (stg[s][c*N+3*g]),
                  .y_i  (stg[s][c*N+3*g+1]),
                  .z_i  (stg[s][c*N+3*g+2]),
                  .sum_o(stg[s+1][c*N+g]),
                  .cy_o (fco[s][c*N+g])
               );
            end else begin : g_idle
               assign fco[s][c*N+g] = 1'b0;
            end
         end

         if (HA != 0) begin : g_ha
            wt_ha u_ha (
               .x_i  (stg[s][c*N+3*F]),
               .y_i  (stg[s][c*N+3*F+1]),
               .sum_o(stg[s+1][c*N+F]),
               .cy_o (hco[s][c])
            );
         end else begin : g_pass
            for (genvar p = 0; p < L; p++) begin : g_bit
               assign stg[s+1][c*N+F+p] = stg[s][c*N+3*F+p];
            end
            assign hco[s][c] = 1'b0;
         end

         for (genvar g = 0; g < FP; g++) begin : g_cin
            assign stg[s+1][c*N+NL+g] = fco[s][(c-1)*N+g];
         end
         if (HP != 0) begin : g_hcin
            assign stg[s+1][c*N+NL+FP] = hco[s][c-1];
         end
         for (genvar k = NL + FP + HP; k < N; k++) begin : g_pad
            assign stg[s+1][c*N+k] = 1'b0;
         end
      end
   end

   if (NS == 0) begin : g_no_stage
      assign fco[0] = '0;
      assign hco[0] = '0;
   end

   for (genvar c = 0; c < W; c++) begin : g_rows
      assign row_x[c] = stg[NS][c*N];
      assign row_y[c] = stg[NS][c*N+1];
   end

   wt_cpa #(.W(W)) u_cpa (.x_i(row_x), .y_i(row_y), .sum_o(prod_o));

   // Each stage must keep the weighted value of the matrix equal to the product.
   for (genvar s = 0; s <= NS; s++) begin : g_value
      always_comb begin
         logic [AW-1:0] acc;
         logic [W-1:0]  want;
         acc  = '0;
         want = {{N{1'b0}}, a_i} * {{N{1'b0}}, b_i};
         for (int c = 0; c < W; c++) begin
            for (int k = 0; k < N; k++) begin
               acc = acc + ({{(AW-1){1'b0}}, stg[s][c*N+k]} << c);
            end
         end
         // R1
         stage_value_chk: assert (acc == {8'd0, want})
            else $error("stage matrix value differs from the product");
      end
   end

   always_comb begin
      logic [W-1:0] want;
      want = {{N{1'b0}}, a_i} * {{N{1'b0}}, b_i};
      // R1
      prod_value_chk: assert (prod_o == want)
         else $error("product differs from operand multiply");
      // R2
      zero_op_chk: assert (!(a_i == '0 || b_i == '0) || prod_o == '0)
         else $error("zero operand gave a nonzero product");
      // R3
      unit_op_chk: assert (b_i != {{(N-1){1'b0}}, 1'b1} || prod_o == {{N{1'b0}}, a_i})
         else $error("unit multiplier changed the multiplicand");
   end
endmodule

// File: tb/wallace_mult_bench.sv
module wallace_mult_bench;
   localparam int N = 10;
   localparam int W = 2 * N;

   logic          clk = 1'b0;
   logic [N-1:0]  a   = '0;
   logic [N-1:0]  b   = '0;
   logic [W-1:0]  prod;
   int            n_cmp = 0;
   int            n_bad = 0;
   int            cyc   = 0;

   wallace_mult #(.N(N)) u_wallace_mult (.a_i(a), .b_i(b), .prod_o(prod));

   always #5 clk = ~clk;

   function automatic logic [W-1:0] mul_ref(logic [N-1:0] x, logic [N-1:0] y);
      logic [W-1:0] ex;
      logic [W-1:0] ey;
      ex = {{N{1'b0}}, x};
      ey = {{N{1'b0}}, y};
      return ex * ey;
   endfunction

   task automatic check(string tag, logic [W-1:0] want);
      n_cmp++;
      if (prod !== want) begin
         n_bad++;
         $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", tag, a, b, prod, want);
      end
   endtask

   // Drive 1 ns after an edge, sample 2 ns later, next drive before the edge after that.
   task automatic apply(logic [N-1:0] x, logic [N-1:0] y, string tag, logic [W-1:0] want);
      a = x;
      b = y;
      #2;
      check(tag, want);
      #3;
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc >= 200000) begin
            n_bad++;
            $display("FAIL watchdog expired after %0d cycles", cyc);
            finish_run();
         end
      end
   end

   initial begin
      #3;
      // R2: state at start with both operands zero
      check("R2 start", '0);
      #3;
      for (int i = 0; i < (1 << N); i++) begin
         apply('0, i[N-1:0], "R2 a zero", '0);
         apply(i[N-1:0], '0, "R2 b zero", '0);
         apply(i[N-1:0], 1, "R3 b one", {{N{1'b0}}, i[N-1:0]});
         apply(1, i[N-1:0], "R3 a one", {{N{1'b0}}, i[N-1:0]});
      end
      // R4: both operands all ones
      apply('1, '1, "R4 max", W'(1046529));
      apply('1, '1, "R4 max ref", mul_ref('1, '1));
      // R5: power-of-two multiplier shifts the multiplicand
      for (int k = 0; k < N; k++) begin
         for (int i = 0; i < (1 << N); i += 3) begin
            apply(i[N-1:0], N'(1 << k), "R5 shift", {{N{1'b0}}, i[N-1:0]} << k);
         end
      end
      // R6: two operand changes inside one clock period, each settled without an edge
      @(posedge clk);
      #1;
      a = 10'd517; b = 10'd999;
      #1;
      check("R6 first change", mul_ref(10'd517, 10'd999));
      a = 10'd3;   b = 10'd1021;
      #1;
      check("R6 second change", mul_ref(10'd3, 10'd1021));
      #3;
      // R1: all multiplicands against a strided set of multipliers; R7 on the swap
      for (int i = 0; i < (1 << N); i++) begin
         for (int j = 0; j < (1 << N); j += 11) begin
            apply(i[N-1:0], j[N-1:0], "R1 sweep", mul_ref(i[N-1:0], j[N-1:0]));
         end
         apply(i[N-1:0], '1, "R1 top multiplier", mul_ref(i[N-1:0], '1));
         if ((i % 37) == 0) begin
            for (int j = 0; j < (1 << N); j += 29) begin
               apply(j[N-1:0], i[N-1:0], "R7 swapped", mul_ref(i[N-1:0], j[N-1:0]));
            end
         end
      end
      finish_run();
   end
endmodule